// File: doc/BRIEF.md
# Weighted Remainder Combining Network for a Strength-Adaptive BCH Encoder

This block produces the parity of a binary BCH codeword from the remainders of a chain of small dividers. Upstream, the shifted message is divided by the first minimal polynomial, that quotient by the second, and so on. Each stage leaves an m-bit remainder. This block folds those remainders together in Horner order. It starts with the last remainder, multiplies the running value by the next lower minimal polynomial and adds the next remainder, until the first remainder has been added. The result equals the shifted message reduced by the product of the first t minimal polynomials. It is sent out one bit per clock, highest coefficient first.

Every multiplication is a serial shift-and-XOR product with no feedback path. The running value therefore never sits in a wide register. It flows as a bit stream through a chain of m-bit multiplier stages, and each remainder is injected into that stream at its own stage. The code strength t is chosen per load with a small input. Going from strength t to t+1 only brings one more stage into use, and the minimal polynomials themselves are the only constants stored. The default build has m = 16, up to twelve remainders, and the eleven multiplier weights of a 16-bit field.

Top module: `horner_parity_combiner`

## Requirements
- R1: While reset is asserted and after it is released, `par_valid`, `par_last` and `par_bit` are all low until a load is accepted.
- R2: A load with `strength` in 1..TMAX, presented while `par_valid` is low, is accepted at that clock edge. `par_valid` is then high for exactly M·strength consecutive cycles, starting in the next cycle.
- R3: `par_last` is high only in the final cycle of a run, which is the M·strength-th valid cycle, and `par_valid` is low in the cycle after it.
- R4: The emitted bits form r = (((r_t·g_(t-1) + r_(t-1))·g_(t-2) + …)·g_1) + r_1 over GF(2), with t = strength. Valid cycle c (from 0) carries the coefficient of x^(M·t−1−c). When the remainders come from the cascaded division of u(x)·x^(M·t), r equals u(x)·x^(M·t) mod (g_1·…·g_t).
- R5: `rem_in` holds remainder r_i in bits [(i−1)·M +: M], and bit M−1 of each slice is the coefficient of x^(M−1). Slices above r_strength have no effect on the output.
- R6: With strength 1 the stream is r_1 itself, MSB first, and no multiplier contributes.
- R7: A load presented while `par_valid` is high is ignored. The current stream, its length and its last flag are unchanged.
- R8: A load with `strength` equal to 0 or greater than TMAX is ignored, and `par_valid` stays low.
- R9: `par_bit` is low in every cycle where `par_valid` is low, including right after a run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Start strobe for a new parity run |
| strength | input | $clog2(TMAX+1) | Number of remainders t used in this run |
| rem_in | input | TMAX·M | Remainders, r_i in slice i−1 |
| par_bit | output | 1 | Serial parity bit, highest coefficient first |
| par_valid | output | 1 | High while parity bits are being emitted |
| par_last | output | 1 | Marks the final parity bit of a run |

## Verification
A load is accepted at the rising edge where it is sampled. The first parity bit and `par_valid` follow in the next cycle, because the bit is formed by logic from registers and no output register adds a stage. Bit c of the run therefore appears c cycles after that first cycle, `par_last` appears M·t−1 cycles after it, and `par_valid` is low M·t cycles after it. The bench drives inputs and samples outputs on the falling edge and walks a cycle index from the first valid cycle. Each bit, the valid level and the last flag are compared against the value expected at that exact index, and two further cycles are checked for a clean idle.

// File: rtl/horner_parity_combiner.sv
module horner_parity_combiner #(
  parameter int M = 16,
  parameter int TMAX = 12,
  parameter logic [(TMAX-1)*M-1:0] WEIGHTS = {
    16'h3A2D, 16'h75A7, 16'h0EA1, 16'h7367, 16'hAF65, 16'hF7B5,
    16'h1F2F, 16'h5A55, 16'h0FBD, 16'h0173, 16'h002D},
  localparam int SW = $clog2(TMAX+1),
  localparam int RW = TMAX*M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] strength,
  input  logic [RW-1:0] rem_in,
  output logic          par_bit,
  output logic          par_valid,
  output logic          par_last
);

  localparam int BW  = $clog2(M);
  localparam int SHW = $clog2(RW+1);

  logic          busy;
  logic [SW-1:0] idx;
  logic [BW-1:0] bcnt;
  logic [RW-1:0] sreg;
  logic [SHW-1:0] shamt;
  logic          strength_ok, accept, run_end, inj;

  assign strength_ok = (strength != '0) && (32'(strength) <= TMAX);
  assign accept      = load && !busy && strength_ok;
  assign run_end     = busy && (idx == SW'(1)) && (bcnt == '0);
  assign shamt       = SHW'((TMAX - 32'(strength)) * M);
  assign inj         = busy & sreg[RW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      bcnt <= '0;
      sreg <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= strength;
      bcnt <= BW'(M-1);
      sreg <= rem_in << shamt;
    end else if (busy) begin
      sreg <= {sreg[RW-2:0], 1'b0};
      if (bcnt == '0) begin
        bcnt <= BW'(M-1);
        idx  <= idx - SW'(1);
        if (idx == SW'(1)) busy <= 1'b0;
      end else begin
        bcnt <= bcnt - BW'(1);
      end
    end
  end

  for (genvar j = TMAX; j >= 1; j--) begin : chain
    logic zo;
    if (j == TMAX) begin : top_stage
      assign zo = inj & (idx == SW'(j));
    end else begin : mul_stage
      localparam logic [M-1:0] GJ = WEIGHTS[(j-1)*M +: M];
      logic [M-1:0] acc;
      logic         din;
      assign din = chain[j+1].zo;
      assign zo  = acc[M-1] ^ din ^ (inj & (idx == SW'(j)));
      always_ff @(posedge clk) begin
        if (!rst_n || accept) acc <= '0;
        else if (busy)        acc <= {acc[M-2:0], 1'b0} ^ (din ? GJ : '0);
      end
    end
  end

  assign par_bit   = chain[1].zo;
  assign par_valid = busy;
  assign par_last  = run_end;

endmodule

// File: rtl/horner_parity_combiner_chk.sv
module horner_parity_combiner_chk #(
  parameter int M = 16,
  parameter int TMAX = 12,
  localparam int SW = $clog2(TMAX+1),
  localparam int CW = $clog2(TMAX*M+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [SW-1:0] strength,
  input logic          par_bit,
  input logic          par_valid,
  input logic          par_last
);

  logic [CW-1:0] run_cnt;
  logic [SW-1:0] t_lat;
  logic          good_load, bad_load;

  assign good_load = load && !par_valid && (strength != '0) && (32'(strength) <= TMAX);
  assign bad_load  = load && !par_valid && ((strength == '0) || (32'(strength) > TMAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      t_lat   <= '0;
    end else if (good_load) begin
      run_cnt <= '0;
      t_lat   <= strength;
    end else if (par_valid) begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_load |=> par_valid);

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |-> (32'(run_cnt) < M*32'(t_lat)));

  // R3
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_last |-> par_valid && (32'(run_cnt) == M*32'(t_lat) - 1));

  // R3
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_last |=> !par_valid);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid && !par_last |=> par_valid);

  // R8
  bad_strength_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_load |=> !par_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_valid |-> !par_bit);

endmodule

bind horner_parity_combiner horner_parity_combiner_chk #(.M(M), .TMAX(TMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .strength(strength),
  .par_bit(par_bit), .par_valid(par_valid), .par_last(par_last));

// File: tb/tb_horner_parity_combiner.sv
module tb_horner_parity_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int M = 16;
  localparam int TMAX = 12;
  localparam int SW = $clog2(TMAX+1);
  localparam int RW = TMAX*M;

  localparam logic [15:0] GLOW [1:12] = '{
    16'h002D, 16'h0173, 16'h0FBD, 16'h5A55, 16'h1F2F, 16'hF7B5,
    16'hAF65, 16'h7367, 16'h0EA1, 16'h75A7, 16'h3A2D, 16'h1AE3};

  localparam logic [35:0] VECS [0:13] = '{
    {4'd1,  32'h8000_0001}, {4'd2,  32'hDEAD_BEEF}, {4'd3,  32'h1234_5678},
    {4'd4,  32'hCAFE_F00D}, {4'd5,  32'h0F0F_F0F0}, {4'd6,  32'h0000_0001},
    {4'd7,  32'h8000_0000}, {4'd8,  32'hA5A5_5A5A}, {4'd9,  32'h7654_3210},
    {4'd10, 32'h0BAD_C0DE}, {4'd11, 32'h3C3C_C3C3}, {4'd12, 32'h1357_9BDF},
    {4'd12, 32'hFFFF_FFFF}, {4'd7,  32'h0000_0000}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [SW-1:0] strength = '0;
  logic [RW-1:0] rem_in = '0;
  logic par_bit, par_valid, par_last;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  horner_parity_combiner dut (
    .clk(clk), .rst_n(rst_n), .load(load), .strength(strength), .rem_in(rem_in),
    .par_bit(par_bit), .par_valid(par_valid), .par_last(par_last));

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] pmul(input logic [255:0] a, input logic [255:0] b);
    logic [255:0] r = '0;
    for (int i = 0; i < 256; i++) if (b[i]) r ^= a << i;
    return r;
  endfunction

  function automatic logic [255:0] pdiv(input logic [255:0] a, input logic [255:0] d,
                                        input int dg, input bit want_q);
    logic [255:0] q = '0;
    for (int i = 255; i >= dg; i--) begin
      if (a[i]) begin
        a ^= d << (i - dg);
        q[i - dg] = 1'b1;
      end
    end
    return want_q ? q : a;
  endfunction

  function automatic logic [255:0] gfull(input int i);
    return {239'b0, 1'b1, GLOW[i]};
  endfunction

  task automatic build(input int t, input logic [31:0] msg,
                       output logic [RW-1:0] rem, output logic [255:0] expv);
    logic [255:0] a, ri, g;
    a = 256'(msg) << (M*t);
    g = 256'h1;
    for (int i = 1; i <= TMAX; i++) begin
      if (i <= t) begin
        ri = pdiv(a, gfull(i), M, 1'b0);
        a  = pdiv(a, gfull(i), M, 1'b1);
        rem[(i-1)*M +: M] = ri[M-1:0];
        g = pmul(g, gfull(i));
      end else begin
        rem[(i-1)*M +: M] = 16'($urandom);
      end
    end
    expv = pdiv(256'(msg) << (M*t), g, M*t, 1'b0);
  endtask

  task automatic run_case(input int t, input logic [RW-1:0] rem, input logic [255:0] expv,
                          input string rs, input int poke);
    logic [255:0] got = '0;
    int vbad = 0, lbad = 0, ibad = 0;
    int n = M*t;
    strength = SW'(t);
    rem_in = rem;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    for (int c = 0; c < n + 2; c++) begin
      if (c < n) begin
        got[n-1-c] = par_bit;
        if (!par_valid) vbad++;
      end else begin
        if (par_valid) vbad++;
        if (par_bit) ibad++;
      end
      if (par_last != (c == n-1)) lbad++;
      if (c == poke) begin
        load = 1'b1;
        strength = SW'(3);
        rem_in = ~rem;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
    end
    load = 1'b0;
    chk(got == expv, {rs, " stream"}, got, expv);
    chk(vbad == 0, {rs, " R2 valid length"}, 256'(vbad), 256'd0);
    chk(lbad == 0, {rs, " R3 last position"}, 256'(lbad), 256'd0);
    chk(ibad == 0, {rs, " R9 idle bit"}, 256'(ibad), 256'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] rem;
    logic [255:0] expv;
    @(negedge clk);
    chk(!par_valid && !par_last && !par_bit, "R1 in reset",
        256'({par_valid, par_last, par_bit}), 256'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!par_valid && !par_last && !par_bit, "R1 after reset",
        256'({par_valid, par_last, par_bit}), 256'd0);

    // R4 R5: table walk, unused slots filled with noise
    for (int v = 0; v < 14; v++) begin
      build(int'(VECS[v][35:32]), VECS[v][31:0], rem, expv);
      run_case(int'(VECS[v][35:32]), rem, expv, "R4 R5 table", -1);
    end

    // R4: random message at every strength
    for (int t = 1; t <= TMAX; t++) begin
      build(t, $urandom, rem, expv);
      run_case(t, rem, expv, "R4 sweep", -1);
    end

    // R6: single remainder passes straight through
    rem = {RW{1'b1}};
    rem[M-1:0] = 16'hA5C3;
    run_case(1, rem, 256'h0A5C3, "R6 passthrough", -1);

    // R7: load during a run is ignored
    build(4, 32'h6B2F_91C4, rem, expv);
    run_case(4, rem, expv, "R7 busy load", 10);
    build(12, 32'h0137_ACE5, rem, expv);
    run_case(12, rem, expv, "R7 busy load late", 100);

    // R8: out-of-range strengths are ignored
    for (int s = 0; s < 3; s++) begin
      int bt = (s == 0) ? 0 : ((s == 1) ? 13 : 15);
      strength = SW'(bt);
      rem_in = {RW{1'b1}};
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk(!par_valid, "R8 bad strength", 256'(par_valid), 256'd0);
      @(negedge clk);
      chk(!par_valid && !par_bit, "R8 bad strength hold",
          256'({par_valid, par_bit}), 256'd0);
    end

    // R9: quiet while idle with noisy inputs
    for (int c = 0; c < 5; c++) begin
      rem_in = {6{32'($urandom)}};
      @(negedge clk);
      chk(!par_valid && !par_bit && !par_last, "R9 idle quiet",
          256'({par_valid, par_bit, par_last}), 256'd0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule